// File: doc/BRIEF.md
# DMA Transfer Handshake Sequencer

This block is the servicing engine of a four-channel direct memory access controller. Each channel holds a configuration (transfer mode, address direction, auto-reload flag, transfer type), a 4-bit page, a 16-bit current address and a 16-bit current count, plus a mask bit. When a device raises its request line and the channel is unmasked, the engine asks the processor for the bus, waits for the grant, then runs transfer frames of three clocks each. Every frame presents a 20-bit memory address, drives the memory/IO strobe pair that matches the transfer type, and acknowledges the serviced device. It then steps the address and count.

The count holds the number of transfers minus one. The final transfer is the one in which the count is zero. On that transfer the engine flags terminal count and releases the bus. Depending on the channel's configuration it then masks the channel or reloads the address and count from the values last loaded. No data passes through the block, so there is no stream interface and no back-pressure. The device request and the bus grant are plain level handshakes. A channel is set up through a one-cycle load strobe and a one-cycle mask write, both applied while the engine is idle.

Top module: `dma_handshake_seq`

## Requirements
- R1: A request on `dreq[c]` is acted on only while channel c is unmasked. A qualified request raises `hrq` one clock after the engine sees it while idle. No frame starts until `hlda` is high.
- R2: Each transfer is a frame of three clocks (address, strobe, update). During all three, `dack` is one-hot for the serviced channel and `mem_addr` equals {page, current address}. `dack` is zero and `mem_addr` is zero outside frames.
- R3: Strobes are high only in the middle clock of a frame. Type 2'b01 (to memory) asserts `mem_wr` and `io_rd`. Type 2'b10 (from memory) asserts `mem_rd` and `io_wr`. Types 2'b00 (verify) and 2'b11 assert no strobe.
- R4: Among simultaneous qualified requests, the lowest channel number wins. Arbitration happens only while the engine is idle.
- R5: The count decrements by one in every frame. `tc` is high in the update clock of the frame whose count was zero. On the clock after `tc`, `hrq` and `dack` are low.
- R6: With `cfg_dec` = 0 the address increments after each frame; with `cfg_dec` = 1 it decrements. The address wraps within 16 bits and never changes the page.
- R7: Without auto-reload, terminal count sets the channel's mask. Its requests are then ignored and `hrq` stays low.
- R8: With auto-reload, terminal count restores the address and count to the loaded values and leaves the channel unmasked.
- R9: Single mode (`cfg_mode` 2'b01, and the unused code 2'b11) drops `hrq` after every frame.
- R10: Demand mode (`cfg_mode` 2'b00) starts another frame at once if the channel's `dreq` is high in the update clock. Otherwise it drops `hrq`.
- R11: Block mode (`cfg_mode` 2'b10) runs frames back to back until terminal count, whatever `dreq` does.
- R12: `cfg_load` writes the configuration, page, address and count of channel `cfg_chan` and unmasks it. `mask_wr` sets (`mask_set` = 1) or clears the mask of channel `mask_chan`.
- R13: After reset, all channels are masked and `hrq`, `dack`, `tc`, the strobes and `mem_addr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq | input | 4 | Device request, one per channel |
| hlda | input | 1 | Bus grant from the processor |
| hrq | output | 1 | Bus request to the processor |
| dack | output | 4 | Device acknowledge, one-hot during a frame |
| mem_addr | output | 20 | {page, current address} during a frame |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| io_rd | output | 1 | IO read strobe |
| io_wr | output | 1 | IO write strobe |
| tc | output | 1 | Terminal count, in the update clock of the last frame |
| cfg_load | input | 1 | Load the channel selected by cfg_chan |
| cfg_chan | input | 2 | Channel to load |
| cfg_mode | input | 2 | 00 demand, 01 single, 10 block, 11 treated as single |
| cfg_dec | input | 1 | 1 selects address decrement |
| cfg_auto | input | 1 | 1 selects reload at terminal count |
| cfg_type | input | 2 | 00 verify, 01 to memory, 10 from memory, 11 none |
| cfg_page | input | 4 | Page bits |
| cfg_addr | input | 16 | Start address |
| cfg_count | input | 16 | Transfers minus one |
| mask_wr | input | 1 | Write one mask bit |
| mask_chan | input | 2 | Channel whose mask is written |
| mask_set | input | 1 | 1 masks, 0 unmasks |

## Verification
A wrong current address shows at `mem_addr` in the first clock of that channel's next frame. A wrong count shows as `tc` in the wrong frame, and the bus is released early or late on the following clock. A mask bit left in the wrong state shows within two clocks of idle: `hrq` either rises for a channel that should be silent or stays low for one that should be served. Sequencer state errors show within one frame, through a broken three-clock `dack` pattern or strobes outside the middle clock.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    XM_DEMAND = 2'b00,
    XM_SINGLE = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_SPARE  = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    XT_VERIFY   = 2'b00,
    XT_TO_MEM   = 2'b01,
    XT_FROM_MEM = 2'b10,
    XT_SPARE    = 2'b11
  } xfer_type_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HOLD,
    S_ADDR,
    S_STRB,
    S_UPD
  } seq_state_e;

  typedef struct packed {
    xfer_mode_e mode;
    logic       dec;
    logic       auto_init;
    xfer_type_e kind;
  } chan_cfg_t;
endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CW-1:0]  win
);
  always_comb begin
    win = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) win = CW'(i);
    end
    any = |req;
  end

  logic [NCH-1:0] below;
  assign below = (NCH'(1) << win) - NCH'(1);

  always_comb begin
    if (any) begin
      a_r4_lowest_wins: assert (req[win] && ((req & below) == '0));
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  chan_cfg_t     ld_cfg,
  input  logic [PW-1:0] ld_page,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] ld_count,
  input  logic          msk_we,
  input  logic          msk_val,
  input  logic          step,
  output chan_cfg_t     cfg,
  output logic [PW-1:0] page,
  output logic [AW-1:0] cur_addr,
  output logic          masked,
  output logic          last
);
  logic [AW-1:0] base_addr, base_cnt, cur_cnt;

  assign last = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      page      <= '0;
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      masked    <= 1'b1;
    end else if (ld) begin
      cfg       <= ld_cfg;
      page      <= ld_page;
      base_addr <= ld_addr;
      base_cnt  <= ld_count;
      cur_addr  <= ld_addr;
      cur_cnt   <= ld_count;
      masked    <= 1'b0;
    end else begin
      if (msk_we) masked <= msk_val;
      if (step) begin
        if (last && cfg.auto_init) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= cfg.dec ? cur_addr - AW'(1) : cur_addr + AW'(1);
          cur_cnt  <= cur_cnt - AW'(1);
          if (last) masked <= 1'b1;
        end
      end
    end
  end

  a_r6_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    step && !ld && !last && !cfg.dec && (cur_addr == '1) |=> (cur_addr == '0));
  a_r6_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    step && !ld && !last && cfg.dec && (cur_addr == '0) |=> (cur_addr == '1));
  a_r7_tc_masks: assert property (@(posedge clk) disable iff (!rst_n)
    step && !ld && last && !cfg.auto_init |=> masked && (cur_cnt == '1));
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    step && !ld && last && cfg.auto_init |=> !masked && (cur_cnt == base_cnt) && (cur_addr == base_addr));
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       hlda,
  input  xfer_mode_e mode,
  input  logic       dreq_sel,
  input  logic       last,
  output seq_state_e st
);
  seq_state_e nx;

  always_comb begin
    nx = st;
    unique case (st)
      S_IDLE: if (start) nx = S_HOLD;
      S_HOLD: if (hlda) nx = S_ADDR;
      S_ADDR: nx = S_STRB;
      S_STRB: nx = S_UPD;
      S_UPD: begin
        if (last) nx = S_IDLE;
        else begin
          unique case (mode)
            XM_BLOCK:  nx = S_ADDR;
            XM_DEMAND: nx = dreq_sel ? S_ADDR : S_IDLE;
            default:   nx = S_IDLE;
          endcase
        end
      end
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nx;
  end

  a_r1_wait_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) && !hlda |=> (st == S_HOLD));
  a_r9_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UPD) && !last && (mode != XM_BLOCK) && (mode != XM_DEMAND) |=> (st == S_IDLE));
  a_r11_block_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UPD) && !last && (mode == XM_BLOCK) |=> (st == S_ADDR));
endmodule

// File: rtl/dma_handshake_seq.sv
module dma_handshake_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int PW  = 4,
  localparam int CW  = $clog2(NCH),
  localparam int MAW = AW + PW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dreq,
  input  logic           hlda,
  output logic           hrq,
  output logic [NCH-1:0] dack,
  output logic [MAW-1:0] mem_addr,
  output logic           mem_wr,
  output logic           mem_rd,
  output logic           io_rd,
  output logic           io_wr,
  output logic           tc,
  input  logic           cfg_load,
  input  logic [CW-1:0]  cfg_chan,
  input  logic [1:0]     cfg_mode,
  input  logic           cfg_dec,
  input  logic           cfg_auto,
  input  logic [1:0]     cfg_type,
  input  logic [PW-1:0]  cfg_page,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [AW-1:0]  cfg_count,
  input  logic           mask_wr,
  input  logic [CW-1:0]  mask_chan,
  input  logic           mask_set
);
  chan_cfg_t      new_cfg;
  chan_cfg_t      cfg_a  [NCH];
  logic [PW-1:0]  page_a [NCH];
  logic [AW-1:0]  addr_a [NCH];
  logic [NCH-1:0] masked_v, last_v, step_v, qual;
  logic           any_q, start, in_frame;
  logic [CW-1:0]  win, sel_q;
  seq_state_e     st;
  chan_cfg_t      sel_cfg;

  assign new_cfg = '{mode: xfer_mode_e'(cfg_mode), dec: cfg_dec,
                     auto_init: cfg_auto, kind: xfer_type_e'(cfg_type)};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_chan_regs #(.AW(AW), .PW(PW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (cfg_load && (cfg_chan == CW'(c))),
      .ld_cfg   (new_cfg),
      .ld_page  (cfg_page),
      .ld_addr  (cfg_addr),
      .ld_count (cfg_count),
      .msk_we   (mask_wr && (mask_chan == CW'(c))),
      .msk_val  (mask_set),
      .step     (step_v[c]),
      .cfg      (cfg_a[c]),
      .page     (page_a[c]),
      .cur_addr (addr_a[c]),
      .masked   (masked_v[c]),
      .last     (last_v[c])
    );
  end

  assign qual = dreq & ~masked_v;

  dma_prio_arb #(.NCH(NCH)) u_arb (
    .req (qual),
    .any (any_q),
    .win (win)
  );

  assign start = (st == S_IDLE) && any_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sel_q <= '0;
    else if (start) sel_q <= win;
  end

  assign sel_cfg = cfg_a[sel_q];

  dma_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .hlda     (hlda),
    .mode     (sel_cfg.mode),
    .dreq_sel (dreq[sel_q]),
    .last     (last_v[sel_q]),
    .st       (st)
  );

  assign in_frame = (st == S_ADDR) || (st == S_STRB) || (st == S_UPD);
  assign step_v   = (st == S_UPD) ? (NCH'(1) << sel_q) : '0;
  assign hrq      = (st != S_IDLE);
  assign dack     = in_frame ? (NCH'(1) << sel_q) : '0;
  assign mem_addr = in_frame ? {page_a[sel_q], addr_a[sel_q]} : '0;
  assign tc       = (st == S_UPD) && last_v[sel_q];

  always_comb begin
    mem_wr = 1'b0;
    mem_rd = 1'b0;
    io_rd  = 1'b0;
    io_wr  = 1'b0;
    if (st == S_STRB) begin
      unique case (sel_cfg.kind)
        XT_TO_MEM:   begin mem_wr = 1'b1; io_rd = 1'b1; end
        XT_FROM_MEM: begin mem_rd = 1'b1; io_wr = 1'b1; end
        default: ;
      endcase
    end
  end

  a_r1_request_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hrq) |-> $past(|(dreq & ~masked_v)));
  a_r2_dack_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> hlda);
  a_r2_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));
  a_r3_strobe_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr == io_rd) && (mem_rd == io_wr) && !(mem_wr && mem_rd));
  a_r5_tc_releases: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !hrq && (dack == '0));
endmodule

// File: tb/tb_dma_handshake_seq.sv
module tb_dma_handshake_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dreq = '0;
  logic        hlda = 1'b0;
  logic        hrq;
  logic [3:0]  dack;
  logic [19:0] mem_addr;
  logic        mem_wr, mem_rd, io_rd, io_wr, tc;
  logic        cfg_load = 1'b0;
  logic [1:0]  cfg_chan = '0, cfg_mode = '0, cfg_type = '0;
  logic        cfg_dec = 1'b0, cfg_auto = 1'b0;
  logic [3:0]  cfg_page = '0;
  logic [15:0] cfg_addr = '0, cfg_count = '0;
  logic        mask_wr = 1'b0, mask_set = 1'b0;
  logic [1:0]  mask_chan = '0;

  dma_handshake_seq dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) hlda <= rst_n ? hrq : 1'b0;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // bench model
  logic [15:0] m_addr[4], m_cnt[4], m_baddr[4], m_bcnt[4];
  logic [3:0]  m_page[4];
  logic [1:0]  m_mode[4], m_type[4];
  logic        m_dec[4], m_auto[4];
  logic [3:0]  m_mask = 4'hF;

  function automatic int lowest(input logic [3:0] v);
    for (int i = 3; i >= 0; i--) if (v[i]) lowest = i;
  endfunction

  function automatic int idx_of(input logic [3:0] v);
    idx_of = 0;
    for (int i = 0; i < 4; i++) if (v[i]) idx_of = i;
  endfunction

  // monitor
  int  phase = 0, pend_win = 0, ch = 0, exp_kind = 0, exp_ch = 0;
  logic [3:0] prev_dack = '0;
  bit  exp_hrq_valid = 0, exp_hrq = 0;
  string exp_tag = "";

  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_hrq_valid) chk(hrq == exp_hrq, "R1 R7 hrq follows qualified requests", hrq, exp_hrq);
      exp_hrq_valid = 0;
      if (exp_kind == 1) chk(!hrq && dack == 0, exp_tag, {hrq, dack}, 0);
      if (exp_kind == 2) chk(dack == (4'b1 << exp_ch), exp_tag, dack, 4'b1 << exp_ch);
      exp_kind = 0;
      if (dack != 0) begin
        ch = idx_of(dack);
        if (prev_dack == 0) begin
          chk(dack == (4'b1 << pend_win), "R4 priority winner", dack, 4'b1 << pend_win);
          phase = 0;
        end else phase = (phase + 1) % 3;
        chk({m_page[ch], m_addr[ch]} == mem_addr, "R2 R6 R8 R12 frame address", mem_addr, {m_page[ch], m_addr[ch]});
        if (phase == 0) begin
          chk(hlda && hrq, "R1 frame only under grant", {hlda, hrq}, 2'b11);
          chk({mem_wr, mem_rd, io_rd, io_wr, tc} == 0, "R3 no strobe in address clock", {mem_wr, mem_rd, io_rd, io_wr, tc}, 0);
        end else if (phase == 1) begin
          logic [3:0] e;
          e = (m_type[ch] == 2'b01) ? 4'b1010 : (m_type[ch] == 2'b10) ? 4'b0101 : 4'b0000;
          chk({mem_wr, mem_rd, io_rd, io_wr} == e, "R3 strobes by type", {mem_wr, mem_rd, io_rd, io_wr}, e);
        end else begin
          bit lst;
          lst = (m_cnt[ch] == 0);
          chk(tc == lst, "R5 tc on last frame", tc, lst);
          if (lst && m_auto[ch]) begin
            m_addr[ch] = m_baddr[ch];
            m_cnt[ch]  = m_bcnt[ch];
          end else begin
            m_addr[ch] = m_dec[ch] ? m_addr[ch] - 16'd1 : m_addr[ch] + 16'd1;
            m_cnt[ch]  = m_cnt[ch] - 16'd1;
            if (lst) m_mask[ch] = 1'b1;
          end
          exp_ch = ch;
          if (lst) begin exp_kind = 1; exp_tag = "R5 release after tc"; end
          else if (m_mode[ch] == 2'b10) begin exp_kind = 2; exp_tag = "R11 block continues"; end
          else if (m_mode[ch] == 2'b00) begin
            exp_kind = dreq[ch] ? 2 : 1;
            exp_tag = "R10 demand follows dreq";
          end else begin exp_kind = 1; exp_tag = "R9 single releases"; end
        end
      end else if (!hrq) begin
        logic [3:0] q;
        chk({mem_wr, mem_rd, io_rd, io_wr, tc, mem_addr} == 0, "R2 R3 quiet while idle",
            {mem_wr, mem_rd, io_rd, io_wr, tc}, 0);
        q = dreq & ~m_mask;
        if (q != 0) pend_win = lowest(q);
        exp_hrq_valid = 1;
        exp_hrq = (q != 0);
      end
      prev_dack = dack;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_ch(input int c, input logic [1:0] md, input bit dec, input bit au,
                         input logic [1:0] ty, input logic [3:0] pg, input logic [15:0] ad,
                         input logic [15:0] cn);
    cfg_chan = 2'(c); cfg_mode = md; cfg_dec = dec; cfg_auto = au; cfg_type = ty;
    cfg_page = pg; cfg_addr = ad; cfg_count = cn; cfg_load = 1'b1;
    m_mode[c] = md; m_dec[c] = dec; m_auto[c] = au; m_type[c] = ty; m_page[c] = pg;
    m_addr[c] = ad; m_baddr[c] = ad; m_cnt[c] = cn; m_bcnt[c] = cn; m_mask[c] = 1'b0;
    tick();
    cfg_load = 1'b0;
  endtask

  task automatic write_mask(input int c, input bit s);
    mask_chan = 2'(c); mask_set = s; mask_wr = 1'b1;
    m_mask[c] = s;
    tick();
    mask_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    dreq = '0;
    for (int k = 0; k < 2000 && quiet < 6; k++) begin
      tick();
      quiet = hrq ? 0 : quiet + 1;
    end
    chk(quiet >= 6, "R5 engine returns idle", quiet, 6);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4; i++) begin
      m_addr[i] = 0; m_cnt[i] = 0; m_baddr[i] = 0; m_bcnt[i] = 0; m_page[i] = 0;
      m_mode[i] = 0; m_type[i] = 0; m_dec[i] = 0; m_auto[i] = 0;
    end
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    // R13 reset state
    chk({hrq, dack, tc, mem_wr, mem_rd, io_rd, io_wr} == 0, "R13 outputs low after reset",
        {hrq, dack, tc, mem_wr, mem_rd, io_rd, io_wr}, 0);
    chk(mem_addr == 0, "R13 address low after reset", mem_addr, 0);
    dreq = 4'hF;
    repeat (5) tick();
    chk(hrq == 1'b0, "R13 all channels masked after reset", hrq, 0);
    dreq = '0;
    tick();

    // R4 priority: all four single transfers requested at once
    for (int c = 0; c < 4; c++) load_ch(c, 2'b01, 0, 0, 2'(c), 4'(c + 1), 16'h1000 * 16'(c), 16'd0);
    tick();
    dreq = 4'hF;
    repeat (40) tick();
    // R7 all masked now, requests still high
    chk(hrq == 1'b0, "R7 finished channels masked", hrq, 0);
    wait_idle();

    // R6 wrap up in block mode, R11
    load_ch(1, 2'b10, 0, 0, 2'b01, 4'h5, 16'hFFFF, 16'd2);
    tick();
    dreq = 4'b0010;
    tick();
    dreq = '0;
    wait_idle();
    chk(m_addr[1] == 16'h0002, "R6 increment wrap", m_addr[1], 16'h0002);
    // R6 wrap down, verify type R3
    load_ch(2, 2'b10, 1, 0, 2'b00, 4'hA, 16'h0001, 16'd3);
    tick();
    dreq = 4'b0100;
    tick();
    dreq = '0;
    wait_idle();
    chk(m_addr[2] == 16'hFFFD, "R6 decrement wrap", m_addr[2], 16'hFFFD);

    // R8 auto-reload in demand mode, R10
    load_ch(3, 2'b00, 0, 1, 2'b10, 4'h3, 16'h1234, 16'd1);
    tick();
    dreq = 4'b1000;
    repeat (30) tick();
    dreq = '0;
    wait_idle();
    dreq = 4'b1000;
    repeat (3) tick();
    chk(hrq == 1'b1, "R8 channel stays unmasked", hrq, 1);
    wait_idle();

    // R12 mask write ignores then re-enables
    write_mask(3, 1);
    tick();
    dreq = 4'b1000;
    repeat (4) tick();
    chk(hrq == 1'b0, "R12 masked channel ignored", hrq, 0);
    dreq = '0;
    tick();
    write_mask(3, 0);
    tick();
    dreq = 4'b1000;
    repeat (4) tick();
    chk(hrq == 1'b1, "R12 unmasked channel served", hrq, 1);
    wait_idle();

    // random episodes
    for (int ep = 0; ep < 150; ep++) begin
      for (int c = 0; c < 4; c++)
        load_ch(c, 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 4'($urandom),
                16'($urandom), 16'($urandom_range(0, 6)));
      if ($urandom_range(0, 3) == 0) write_mask($urandom_range(0, 3), 1);
      tick();
      for (int k = 0; k < 40; k++) begin
        dreq = 4'($urandom);
        tick();
      end
      wait_idle();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule